// File: doc/BRIEF.md
# Segmented Step-Error Code Corrector

This block sits behind a two-stage pipelined converter and removes a periodic step error from its output. A 10-bit raw code, the 4-bit coarse code that the first stage resolved, and a valid strobe arrive each sample. A single signed fractional step-error value, supplied from outside, is scaled by the signed segment weight `2*seg - 15`. That weight is zero only between the two middle segments and grows by two per segment outward. The scaled value is added to the raw code after the raw code has been re-centred on mid-scale (raw minus 512). The result is a signed fixed-point code with 12 fractional bits. Segments below the centre move in one direction and segments above it move in the other, by equal amounts.

The step-error value is held in an internal register that changes only when a load strobe is given. This lets an estimator on a slower calibration timebase present a new value at a chosen boundary while the sample stream runs without pause. The corrected code and its valid flag are registered one cycle after the input.

Top module: `seg_step_corrector`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears `corr_valid` to 0, `corr_code` to 0 and the held step error to 0. The first sample after reset without a load is therefore corrected with a step error of zero.
- R2: `corr_valid` equals `smp_valid` of the previous clock edge whenever reset was low at that edge.
- R3: For a sample accepted with `smp_valid` high, `corr_code` in the next cycle equals `(raw_code - 512) * 4096 + S * (2*seg_code - 15)` as a 24-bit two's complement value. `S` is the held step error, read as a signed 16-bit integer in units of 2^-12 LSB.
- R4: With the same raw code and step error, coarse codes `c` and `15 - c` give offsets of equal size and opposite sign about the centred raw value.
- R5: When `step_load` is high at an edge, the held step error takes `step_new` for every sample from the next cycle on. A sample accepted at that same edge still uses the old value.
- R6: While `step_load` is low, `step_new` has no effect on the held step error or on any corrected code.
- R7: While `smp_valid` is low, `corr_code` keeps its last value and `corr_valid` is 0.
- R8: The full-scale corners (raw 0 and 1023, coarse 0 and 15, step error -32768 and +32767) are corrected exactly without wrap-around.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_valid | input | 1 | Sample present this cycle |
| raw_code | input | 10 | Uncorrected converter code, unsigned |
| seg_code | input | 4 | First-stage coarse code, selects segment 0..15 |
| step_new | input | 16 | Candidate step error, signed, 12 fractional bits |
| step_load | input | 1 | Take `step_new` into the held step error |
| corr_valid | output | 1 | Corrected code valid |
| corr_code | output | 24 | Corrected code, signed, 12 fractional bits |

## Verification
A load of a new step error and a sample correction can happen at the same clock edge. The sample must then still see the previous step error, and the new value must show only from the following sample. The bench provokes this by raising `step_load` together with `smp_valid` on single cycles and on several cycles in a row, each time with a different `step_new`. Its behavioural model updates its own copy of the step error only after computing that cycle's expected code, so any early or late take-over appears as a code mismatch on the very sample concerned.

// File: rtl/seg_corr_pkg.sv
package seg_corr_pkg;
  localparam int DEF_RAW_W  = 10;
  localparam int DEF_SEG_W  = 4;
  localparam int DEF_STEP_W = 16;
  localparam int DEF_FRAC_W = 12;

  // Width of signed segment weight 2*seg-(2^SEG_W-1)
  function automatic int weight_width(input int seg_w);
    return seg_w + 2;
  endfunction

  // Width needed for the corrected code
  function automatic int out_width(input int raw_w, input int seg_w,
                                   input int step_w, input int frac_w);
    int a;
    int b;
    a = raw_w + 1 + frac_w;
    b = step_w + seg_w + 2;
    return ((a > b) ? a : b) + 1;
  endfunction
endpackage

// File: rtl/seg_step_hold.sv
module seg_step_hold #(
  parameter int STEP_W = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     load,
  input  logic signed [STEP_W-1:0] step_in,
  output logic signed [STEP_W-1:0] step_q
);
  always_ff @(posedge clk) begin
    if (rst)       step_q <= '0;
    else if (load) step_q <= step_in;
  end
endmodule

// File: rtl/seg_weight.sv
module seg_weight #(
  parameter int SEG_W = 4,
  parameter int WGT_W = SEG_W + 2
) (
  input  logic [SEG_W-1:0]        seg,
  output logic signed [WGT_W-1:0] wgt
);
  localparam int SEG_TOP = (1 << SEG_W) - 1;

  function automatic logic signed [WGT_W-1:0] seg_to_weight(input logic [SEG_W-1:0] s);
    logic [WGT_W-1:0] twice;
    twice = {1'b0, s, 1'b0};
    return $signed(twice - WGT_W'(SEG_TOP));
  endfunction

  assign wgt = seg_to_weight(seg);
endmodule

// File: rtl/seg_offset_sum.sv
module seg_offset_sum #(
  parameter int RAW_W  = 10,
  parameter int STEP_W = 16,
  parameter int FRAC_W = 12,
  parameter int WGT_W  = 6,
  parameter int OUT_W  = 24
) (
  input  logic [RAW_W-1:0]         raw,
  input  logic signed [STEP_W-1:0] step,
  input  logic signed [WGT_W-1:0]  wgt,
  output logic signed [OUT_W-1:0]  sum
);
  localparam int CEN_W  = RAW_W + 1;
  localparam int PROD_W = STEP_W + WGT_W;
  localparam logic [CEN_W-1:0] MID = CEN_W'(1 << (RAW_W - 1));

  function automatic logic signed [OUT_W-1:0] centre_scaled(input logic [RAW_W-1:0] r);
    logic [CEN_W-1:0] c;
    logic [CEN_W+FRAC_W-1:0] sh;
    c  = {1'b0, r} - MID;
    sh = {c, {FRAC_W{1'b0}}};
    return $signed({{(OUT_W-CEN_W-FRAC_W){sh[CEN_W+FRAC_W-1]}}, sh});
  endfunction

  function automatic logic signed [OUT_W-1:0] scaled_step(input logic signed [STEP_W-1:0] s,
                                                          input logic signed [WGT_W-1:0] w);
    logic signed [PROD_W-1:0] se;
    logic signed [PROD_W-1:0] we;
    logic signed [PROD_W-1:0] p;
    se = $signed({{(PROD_W-STEP_W){s[STEP_W-1]}}, s});
    we = $signed({{(PROD_W-WGT_W){w[WGT_W-1]}}, w});
    p  = se * we;
    return $signed({{(OUT_W-PROD_W){p[PROD_W-1]}}, p});
  endfunction

  logic signed [OUT_W-1:0] base_w;
  logic signed [OUT_W-1:0] offs_w;

  assign base_w = centre_scaled(raw);
  assign offs_w = scaled_step(step, wgt);
  assign sum    = base_w + offs_w;
endmodule

// File: rtl/seg_step_corrector.sv
module seg_step_corrector
  import seg_corr_pkg::*;
#(
  parameter int RAW_W  = DEF_RAW_W,
  parameter int SEG_W  = DEF_SEG_W,
  parameter int STEP_W = DEF_STEP_W,
  parameter int FRAC_W = DEF_FRAC_W,
  parameter int WGT_W  = weight_width(SEG_W),
  parameter int OUT_W  = out_width(RAW_W, SEG_W, STEP_W, FRAC_W)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    smp_valid,
  input  logic [RAW_W-1:0]        raw_code,
  input  logic [SEG_W-1:0]        seg_code,
  input  logic [STEP_W-1:0]       step_new,
  input  logic                    step_load,
  output logic                    corr_valid,
  output logic [OUT_W-1:0]        corr_code
);
  logic signed [STEP_W-1:0] step_cur;
  logic signed [WGT_W-1:0]  seg_wgt;
  logic signed [OUT_W-1:0]  sum_w;

  seg_step_hold #(.STEP_W(STEP_W)) hold_i (
    .clk    (clk),
    .rst    (rst),
    .load   (step_load),
    .step_in($signed(step_new)),
    .step_q (step_cur)
  );

  seg_weight #(.SEG_W(SEG_W), .WGT_W(WGT_W)) wgt_i (
    .seg(seg_code),
    .wgt(seg_wgt)
  );

  seg_offset_sum #(
    .RAW_W (RAW_W),
    .STEP_W(STEP_W),
    .FRAC_W(FRAC_W),
    .WGT_W (WGT_W),
    .OUT_W (OUT_W)
  ) sum_i (
    .raw (raw_code),
    .step(step_cur),
    .wgt (seg_wgt),
    .sum (sum_w)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      corr_valid <= 1'b0;
      corr_code  <= '0;
    end else begin
      corr_valid <= smp_valid;
      if (smp_valid) corr_code <= sum_w;
    end
  end
endmodule

// File: rtl/seg_step_corrector_chk.sv
module seg_step_corrector_chk #(
  parameter int RAW_W  = 10,
  parameter int SEG_W  = 4,
  parameter int STEP_W = 16,
  parameter int FRAC_W = 12,
  parameter int WGT_W  = 6,
  parameter int OUT_W  = 24
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    smp_valid,
  input logic [RAW_W-1:0]        raw_code,
  input logic [SEG_W-1:0]        seg_code,
  input logic [STEP_W-1:0]       step_new,
  input logic                    step_load,
  input logic                    corr_valid,
  input logic [OUT_W-1:0]        corr_code,
  input logic signed [STEP_W-1:0] step_cur,
  input logic signed [WGT_W-1:0] seg_wgt
);
  localparam int CEN_W = RAW_W + 1;
  localparam logic [CEN_W-1:0] MID = CEN_W'(1 << (RAW_W - 1));
  localparam int SEG_TOP = (1 << SEG_W) - 1;

  logic [CEN_W-1:0] cen_w;
  logic [OUT_W-1:0] plain_w;
  assign cen_w   = {1'b0, raw_code} - MID;
  assign plain_w = OUT_W'($signed({cen_w, {FRAC_W{1'b0}}}));

  // R1: reset clears outputs
  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (!corr_valid && corr_code == '0));

  // R2: valid follows input by one cycle
  p_valid_follow_r2: assert property (@(posedge clk) disable iff (rst)
    smp_valid |=> corr_valid);
  p_valid_drop_r2: assert property (@(posedge clk) disable iff (rst)
    !smp_valid |=> !corr_valid);

  // R7: output held when no sample
  p_hold_code_r7: assert property (@(posedge clk) disable iff (rst)
    !smp_valid |=> $stable(corr_code));

  // R6: step error untouched without a load
  p_step_keep_r6: assert property (@(posedge clk) disable iff (rst)
    !step_load |=> $stable(step_cur));

  // R5: load takes the candidate value
  p_step_load_r5: assert property (@(posedge clk) disable iff (rst)
    step_load |=> (step_cur == $signed($past(step_new))));

  // R3: with zero step error the output is the centred, scaled raw code
  p_zero_step_r3: assert property (@(posedge clk) disable iff (rst)
    (smp_valid && step_cur == '0) |=> (corr_code == $past(plain_w)));

  // R4: segment weight is odd and mirrors about the centre
  always @(posedge clk) begin
    if (!rst) begin
      p_weight_mirror_r4: assert (seg_wgt[0] == 1'b1 &&
        (seg_wgt + $signed(WGT_W'(SEG_TOP)) == $signed({1'b0, seg_code, 1'b0})));
    end
  end
endmodule

bind seg_step_corrector seg_step_corrector_chk #(
  .RAW_W (RAW_W),
  .SEG_W (SEG_W),
  .STEP_W(STEP_W),
  .FRAC_W(FRAC_W),
  .WGT_W (WGT_W),
  .OUT_W (OUT_W)
) chk_i (
  .clk       (clk),
  .rst       (rst),
  .smp_valid (smp_valid),
  .raw_code  (raw_code),
  .seg_code  (seg_code),
  .step_new  (step_new),
  .step_load (step_load),
  .corr_valid(corr_valid),
  .corr_code (corr_code),
  .step_cur  (step_cur),
  .seg_wgt   (seg_wgt)
);

// File: tb/seg_step_corrector_tb.sv
`timescale 1ns/1ps
module seg_step_corrector_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        smp_valid = 1'b0;
  logic [9:0]  raw_code = '0;
  logic [3:0]  seg_code = '0;
  logic [15:0] step_new = '0;
  logic        step_load = 1'b0;
  logic        corr_valid;
  logic [23:0] corr_code;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  longint m_step = 0;
  longint m_code = 0;
  bit     m_valid = 0;

  always #5 clk = ~clk;

  seg_step_corrector dut_i (
    .clk(clk), .rst(rst), .smp_valid(smp_valid), .raw_code(raw_code),
    .seg_code(seg_code), .step_new(step_new), .step_load(step_load),
    .corr_valid(corr_valid), .corr_code(corr_code)
  );

  function automatic longint got_code();
    return longint'($signed(corr_code));
  endfunction

  task automatic check(input string req, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // One clock of stimulus; model updates its step copy after using it
  task automatic run_cycle(input bit v, input int raw, input int seg,
                           input int stp, input bit ld, input string req);
    smp_valid = v;
    raw_code  = raw[9:0];
    seg_code  = seg[3:0];
    step_new  = stp[15:0];
    step_load = ld;
    @(posedge clk);
    if (v) m_code = longint'(raw - 512) * 4096 + m_step * longint'(2 * seg - 15);
    m_valid = v;
    if (ld) m_step = longint'($signed(stp[15:0]));
    @(negedge clk);
    check({req, " valid"}, longint'(corr_valid), longint'(m_valid));
    check({req, " code"}, got_code(), m_code);
  endtask

  longint sym_a;

  initial begin
    @(negedge clk);
    smp_valid = 1'b1; step_load = 1'b1; step_new = 16'h1234; raw_code = 10'd900;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    smp_valid = 1'b0; step_load = 1'b0;
    // R1: cleared outputs after reset
    check("R1 valid", longint'(corr_valid), 0);
    check("R1 code", got_code(), 0);
    // R1: held step is zero, R6: step_new ignored without load
    run_cycle(1, 700, 3, 999, 0, "R1/R6 zero step");
    run_cycle(1, 100, 14, -5000, 0, "R6 ignored candidate");
    // R5: load and sample at the same edge
    run_cycle(1, 300, 2, 3000, 1, "R5 same-edge old value");
    run_cycle(1, 300, 2, 0, 0, "R5 new value used");
    // R3: sweep all segments
    for (int s = 0; s < 16; s++)
      run_cycle(1, (s * 64 + 17) % 1024, s, 0, 0, "R3 sweep");
    // R4: mirror segments at mid-scale
    for (int s = 0; s < 8; s++) begin
      run_cycle(1, 512, s, 0, 0, "R4 low side");
      sym_a = got_code();
      run_cycle(1, 512, 15 - s, 0, 0, "R4 high side");
      check("R4 mirror", got_code(), -sym_a);
    end
    // R7: idle cycles hold code while inputs wander
    run_cycle(0, 5, 0, 777, 0, "R7 idle");
    run_cycle(0, 1000, 15, -777, 0, "R7 idle");
    // R5: back-to-back loads with samples
    run_cycle(1, 640, 9, -1200, 1, "R5 chain");
    run_cycle(1, 641, 10, 2500, 1, "R5 chain");
    run_cycle(1, 642, 11, -7, 1, "R5 chain");
    run_cycle(1, 643, 12, -7, 0, "R5 chain end");
    // R5: load without a sample, then R7 hold
    run_cycle(0, 1, 1, 16'h4000, 1, "R5/R7 load idle");
    run_cycle(1, 1, 1, 0, 0, "R5 after idle load");
    // R8: corners
    run_cycle(1, 0, 0, -32768, 1, "R8 load min");
    run_cycle(1, 0, 0, 0, 0, "R8 raw0 seg0 min");
    run_cycle(1, 1023, 15, 0, 0, "R8 raw max seg15 min");
    run_cycle(1, 1023, 0, 32767, 1, "R8 load max");
    run_cycle(1, 1023, 15, 0, 0, "R8 raw max seg15 max");
    run_cycle(1, 0, 0, 0, 0, "R8 raw0 seg0 max");
    // R2: alternating valid
    for (int i = 0; i < 6; i++)
      run_cycle(i % 2, 200 + i, i, 0, 0, "R2 alternate");
    // R1: reset mid-stream clears outputs and step
    smp_valid = 1'b1; rst = 1'b1;
    @(negedge clk);
    rst = 1'b0; smp_valid = 1'b0;
    check("R1 mid reset valid", longint'(corr_valid), 0);
    check("R1 mid reset code", got_code(), 0);
    m_step = 0; m_code = 0;
    run_cycle(1, 800, 0, 0, 0, "R1 step cleared");
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1000000;
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule